// File: doc/BRIEF.md
# Programmable Prescaler Interval Timer

This block is an interval timer. It counts single-cycle enable pulses taken from one of two sources, a system-rate tick or a slower sub-clock tick, and divides them by a ratio picked from an eight-entry table that runs from 2 to 16384. The table is not spaced evenly. At every interval boundary the timer can raise a one-cycle interrupt request, which a mask bit can suppress. It also flips a divided square-wave output. A bypass bit selects what drives the timer output pin: that square wave, or the raw sub-clock tick.

Software programs the block through a 4-bit write port with a one-bit register select. The first register (select 0) holds the divider code and a restart flag. The second register (select 1) holds the bypass, source-select and mask bits. A write to the first register can restart the count from zero, but only when an external watchdog-lock input allows it. All logic runs in one clock domain. The reset input asserts asynchronously and is released through a two-stage synchronizer.

Top module: `interval_timer`

## Requirements
- R1: After reset, `irq` is 0 and `tmr_out` is 0. The divider code is 111 (16384). Bypass, source select and mask all read as 1: divided output, sub-clock source, interrupt masked.
- R2: A write with `wr_sel`=0 stores `wr_data[2:0]` as the divider code: 000=2, 001=4, 010=8, 011=16, 100=32, 101=256, 110=2048, 111=16384.
- R3: A write with `wr_sel`=1 stores `wr_data[1]` as source select. With 1, only `sub_tick` pulses advance the count. With 0, only `sys_tick` pulses advance it. Pulses from the unselected source have no effect.
- R4: When an enable arrives and the count is at divider-1 or above, the count wraps to 0 and the divided output toggles. If the mask (`wr_sel`=1, `wr_data[0]`) was 0 before that clock edge, `irq` is 1 for the following cycle.
- R5: A `wr_sel`=0 write with `wr_data[3]`=1 while `wdog_lock`=1 resets the count to 0. That cycle produces no interval boundary.
- R6: While `wdog_lock`=0, a `wr_sel`=0 write never restarts the count. The divider code is still stored.
- R7: A `wr_sel`=0 write with `wr_data[3]`=0 stores the divider code and leaves the running count unchanged.
- R8: After a divider change without restart, if the count is already at or beyond the new divider-1, the next enable wraps it.
- R9: A write with `wr_sel`=1 stores `wr_data[2]` as bypass. With 0, `tmr_out` equals `sub_tick` combinationally. With 1, `tmr_out` is the divided square wave, whose period is twice the interval.
- R10: `wr_data[3]` of a `wr_sel`=1 write has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 divider/restart, 1 output/source/mask |
| wr_data | input | 4 | Write data nibble |
| wdog_lock | input | 1 | 1 allows a write to restart the count |
| sys_tick | input | 1 | System-rate enable pulse |
| sub_tick | input | 1 | Sub-clock enable pulse |
| irq | output | 1 | One-cycle interval interrupt request |
| tmr_out | output | 1 | Timer output: divided square wave or raw sub-clock |

## Verification
The divider is first driven with an enable on every cycle for each of the eight codes, which shows whether each table entry gives its own interval length. Directed sequences then drive only the unselected source, which separates source selection from counting. Restart writes are issued under each combination of the restart flag and the lock input, which separates restart, lock and plain store. A shrink of the divider below the running count shows whether the wrap rule is at-or-beyond or exact-match. A long random phase mixes sparse ticks on both sources with random writes of every kind, which exposes ordering faults between writes and wraps landing on the same edge.

// File: rtl/itm_pkg.sv
package itm_pkg;

  localparam int unsigned DIV_SEL_W = 3;
  localparam int unsigned CTL_W     = 4;

  typedef logic [DIV_SEL_W-1:0] div_sel_t;

  // Divider is two to the returned power; the table bends after code 4.
  function automatic int unsigned div_exp(input div_sel_t code);
    int unsigned v;
    v = 32'(code);
    if (v < 32'd5) return v + 32'd1;
    return (32'd3 * v) - 32'd7;
  endfunction

endpackage

// File: rtl/itm_rst_sync.sv
module itm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/itm_regs.sv
module itm_regs
  import itm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             wdog_lock,
  output div_sel_t         div_sel,
  output logic             bypass,
  output logic             clk_sel,
  output logic             mask,
  output logic             restart
);

  div_sel_t div_q, div_d;
  logic     byp_q, byp_d;
  logic     cs_q, cs_d;
  logic     msk_q, msk_d;
  logic     wr_div, wr_ctl;

  assign wr_div = wr_en & ~wr_sel;
  assign wr_ctl = wr_en &  wr_sel;

  always_comb begin
    div_d = div_q;
    byp_d = byp_q;
    cs_d  = cs_q;
    msk_d = msk_q;
    if (wr_div) div_d = wr_data[DIV_SEL_W-1:0];
    if (wr_ctl) begin
      byp_d = wr_data[2];
      cs_d  = wr_data[1];
      msk_d = wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '1;
      byp_q <= 1'b1;
      cs_q  <= 1'b1;
      msk_q <= 1'b1;
    end else begin
      div_q <= div_d;
      byp_q <= byp_d;
      cs_q  <= cs_d;
      msk_q <= msk_d;
    end
  end

  // Restart request: flag in bit 3, gated by the external lock.
  assign restart = wr_div & wr_data[CTL_W-1] & wdog_lock;
  assign div_sel = div_q;
  assign bypass  = byp_q;
  assign clk_sel = cs_q;
  assign mask    = msk_q;

endmodule

// File: rtl/itm_count.sv
module itm_count
  import itm_pkg::*;
#(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             restart,
  input  div_sel_t         div_sel,
  output logic             wrap,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] term;

  always_comb begin
    term = CNT_W'((32'd1 << div_exp(div_sel)) - 32'd1);
  end

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (restart) begin
      cnt_d = '0;
    end else if (tick_en) begin
      if (cnt_q >= term) begin
        cnt_d = '0;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/itm_out.sv
module itm_out (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic mask,
  input  logic bypass,
  input  logic sub_tick,
  output logic irq,
  output logic tog,
  output logic tmr_out
);

  logic irq_q, irq_d;
  logic tog_q, tog_d;

  always_comb begin
    irq_d = wrap & ~mask;
    tog_d = tog_q ^ wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      tog_q <= tog_d;
    end
  end

  assign irq     = irq_q;
  assign tog     = tog_q;
  assign tmr_out = bypass ? tog_q : sub_tick;

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itm_pkg::*;
#(
  parameter int unsigned CNT_W     = 14,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             wdog_lock,
  input  logic             sys_tick,
  input  logic             sub_tick,
  output logic             irq,
  output logic             tmr_out
);

  localparam int unsigned MAX_EXP = div_exp('1);

  logic             rst_sync_n;
  div_sel_t         div_sel;
  logic             bypass, clk_sel, mask, restart;
  logic             tick_en, wrap, tog;
  logic [CNT_W-1:0] cnt;

  generate
    if (CNT_W < MAX_EXP) begin : g_width_bad
      initial $error("CNT_W too narrow for the largest divider");
    end
  endgenerate

  itm_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  itm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .wdog_lock (wdog_lock),
    .div_sel   (div_sel),
    .bypass    (bypass),
    .clk_sel   (clk_sel),
    .mask      (mask),
    .restart   (restart)
  );

  assign tick_en = clk_sel ? sub_tick : sys_tick;

  itm_count #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_en (tick_en),
    .restart (restart),
    .div_sel (div_sel),
    .wrap    (wrap),
    .cnt     (cnt)
  );

  itm_out u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wrap     (wrap),
    .mask     (mask),
    .bypass   (bypass),
    .sub_tick (sub_tick),
    .irq      (irq),
    .tog      (tog),
    .tmr_out  (tmr_out)
  );

endmodule

// File: rtl/itm_chk.sv
module itm_chk #(
  parameter int unsigned CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [3:0]       wr_data,
  input logic             wdog_lock,
  input logic             tick_en,
  input logic             mask,
  input logic             wrap,
  input logic             tog,
  input logic             irq,
  input logic [CNT_W-1:0] cnt
);

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R4
  irq_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!$past(mask) && $past(wrap)));

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && wr_data[3] && wdog_lock) |=> (cnt == '0));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !(wr_en && !wr_sel && wr_data[3] && wdog_lock)) |=> $stable(cnt));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

  // R9
  toggle_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tog != $past(tog)) |-> $past(wrap));

endmodule

bind interval_timer itm_chk #(.CNT_W(CNT_W)) u_itm_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .wdog_lock (wdog_lock),
  .tick_en   (tick_en),
  .mask      (mask),
  .wrap      (wrap),
  .tog       (tog),
  .irq       (irq),
  .cnt       (cnt)
);

// File: tb/test_interval_timer.sv
module test_interval_timer;

  logic       clk;
  logic       rst_n;
  logic       wr_en, wr_sel, wdog_lock, sys_tick, sub_tick;
  logic [3:0] wr_data;
  logic       irq, tmr_out;

  int tests_run;
  int tests_failed;

  // Reference state built from the requirements.
  logic [2:0]  m_div;
  logic        m_byp, m_cs, m_mask, m_tog, m_irq;
  int unsigned m_cnt;

  interval_timer i_interval_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .wdog_lock (wdog_lock),
    .sys_tick  (sys_tick),
    .sub_tick  (sub_tick),
    .irq       (irq),
    .tmr_out   (tmr_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int unsigned ratio_of(input logic [2:0] code);
    case (code)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 16;
      3'd4: return 32;
      3'd5: return 256;
      3'd6: return 2048;
      default: return 16384;
    endcase
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
  endtask

  // One cycle: drive at the falling edge, update the model, compare after the rising edge.
  task automatic step(input string tag, input logic we, input logic sel, input logic [3:0] d,
                      input logic lock, input logic sy, input logic sb);
    logic en, wrap_m;
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; wdog_lock = lock;
    sys_tick = sy; sub_tick = sb;
    en     = m_cs ? sb : sy;
    wrap_m = 1'b0;
    if (we && !sel && d[3] && lock) begin
      m_cnt = 0;
    end else if (en) begin
      if (m_cnt >= ratio_of(m_div) - 1) begin
        m_cnt  = 0;
        wrap_m = 1'b1;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
    m_irq = wrap_m & ~m_mask;
    m_tog = m_tog ^ wrap_m;
    if (we && !sel) m_div = d[2:0];
    if (we && sel) begin
      m_byp = d[2]; m_cs = d[1]; m_mask = d[0];
    end
    @(posedge clk);
    #1;
    check({tag, " irq"}, irq, m_irq);
    check({tag, " tmr_out"}, tmr_out, m_byp ? m_tog : sb);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic sys_run(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests_failed++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    int pulses;
    void'($urandom(32'h5eed_1234));
    tests_run = 0; tests_failed = 0;
    rst_n = 1'b0;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = 4'h0; wdog_lock = 1'b1;
    sys_tick = 1'b0; sub_tick = 1'b0;
    m_div = 3'd7; m_byp = 1'b1; m_cs = 1'b1; m_mask = 1'b1;
    m_tog = 1'b0; m_irq = 1'b0; m_cnt = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1 irq in reset", irq, 1'b0);
    check("R1 tmr_out in reset", tmr_out, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 irq after release", irq, 1'b0);

    // R1: default is sub-clock source, so system ticks do nothing; output divided
    step("R1 default source", 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b1);

    // R9: bypass off, system source, unmasked
    step("R9 set bypass", 1'b1, 1'b1, 4'b0000, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++)
      step("R9 raw sub-clock", 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'($urandom_range(0, 1)));
    step("R9 divided", 1'b1, 1'b1, 4'b0100, 1'b1, 1'b0, 1'b0);

    // R2: every divider code, enable each cycle, counted pulses
    for (int c = 0; c < 8; c++) begin
      step("R2 load", 1'b1, 1'b0, {1'b1, 3'(c)}, 1'b1, 1'b0, 1'b0);
      pulses = 0;
      for (int i = 0; i < 2 * int'(ratio_of(3'(c))); i++) begin
        step("R2 run", 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0);
        pulses += int'(irq);
      end
      tests_run++;
      if (pulses != 2) begin
        tests_failed++;
        $display("FAIL R2 code %0d: actual %0d pulses expected 2", c, pulses);
      end
    end

    // R3: system source ignores sub ticks, then sub source ignores system ticks
    step("R3 load", 1'b1, 1'b0, 4'b1001, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++) step("R3 sub ignored", 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1);
    step("R3 to sub", 1'b1, 1'b1, 4'b0110, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 12; i++) step("R3 sys ignored", 1'b0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 9; i++) step("R3 sub counted", 1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1);
    step("R3 to sys", 1'b1, 1'b1, 4'b0100, 1'b1, 1'b0, 1'b0);

    // R4: masked wrap toggles output but raises no irq
    step("R4 mask", 1'b1, 1'b1, 4'b0101, 1'b1, 1'b0, 1'b0);
    sys_run("R4 masked", 40);
    step("R4 unmask", 1'b1, 1'b1, 4'b0100, 1'b1, 1'b0, 1'b0);
    sys_run("R4 unmasked", 40);

    // R5, R6, R7: restart variants on divider 16
    step("R5 load", 1'b1, 1'b0, 4'b1011, 1'b1, 1'b0, 1'b0);
    sys_run("R6 pre", 10);
    step("R6 locked restart", 1'b1, 1'b0, 4'b1011, 1'b0, 1'b0, 1'b0);
    sys_run("R6 post", 8);
    step("R7 no restart flag", 1'b1, 1'b0, 4'b0011, 1'b1, 1'b0, 1'b0);
    sys_run("R7 post", 8);
    step("R5 restart", 1'b1, 1'b0, 4'b1011, 1'b1, 1'b1, 1'b0);
    sys_run("R5 post", 20);

    // R8: shrink divider below the running count
    step("R8 load 256", 1'b1, 1'b0, 4'b1101, 1'b1, 1'b0, 1'b0);
    sys_run("R8 climb", 100);
    step("R8 shrink", 1'b1, 1'b0, 4'b0011, 1'b1, 1'b0, 1'b0);
    sys_run("R8 wrap next", 20);

    // R10: bit 3 of the second register changes nothing
    step("R10 write", 1'b1, 1'b1, 4'b1100, 1'b1, 1'b0, 1'b0);
    sys_run("R10 post", 40);

    // Random phase over R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 6000; i++) begin
      logic we;
      logic [3:0] d;
      we = ($urandom_range(0, 15) == 0);
      d  = 4'($urandom);
      if (!d[3] && $urandom_range(0, 3) != 0) d[2:0] = 3'($urandom_range(0, 4));
      step("R8 random", we, 1'($urandom), d, 1'($urandom),
           ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0));
    end

    summary();
    $finish;
  end

endmodule